// File: doc/BRIEF.md
# Display timing engine

A programmable video timing generator for a parallel panel interface. Two counters advance once per pixel clock: one for the position in the current line and one for the position in the whole frame. From them the block produces horizontal sync, vertical sync and a data-enable window. Line timing is given in pixel clocks from the line start. Vertical sync length and the vertical display window are given as absolute pixel-clock offsets from the frame start, so the active window may open or close part way through a line. A common skew value shifts both vertical window bounds.

Pixels come from an upstream source through a valid/ready handshake and are accepted only inside the display window. Outside the window the block drives a programmable border colour. Inside the window, when the source has no pixel ready, it drives a programmable underflow colour. Each colour component is then cut down to the panel depth. A line counter and a frame counter can be read at the ports, and a one-cycle pulse marks each frame start.

All timing settings pass through a shadow copy that is loaded only at a frame start, so a frame never mixes old and new values. Clearing the enable lets the current frame run to its end.

Top module: `disp_tg_top`

## Requirements
- R1: After reset the engine is idle: hsync_o, vsync_o, de_o, pix_ready_o, vblank_o are 0, pix_o is 0, and line_cnt_o and frame_cnt_o are 0. Reset register values are all zero except the underflow colour (0x0000FF) and the format (0x3F).
- R2: While running, the line position counts 0 to HPER-1 and then restarts. The line is active-level hsync for positions below HPW. Register 1 holds HPER in bits [15:0] and HPW in bits [31:16].
- R3: The frame position counts 0 to VPER-1 (register 2) and restarts with the line position. vsync is at the active level for frame positions below VSW (register 3).
- R4: The horizontal window covers line positions HBEG to HFIN inclusive. Register 4 holds HBEG in bits [15:0] and HFIN in bits [31:16].
- R5: The vertical window covers frame positions VBEG+SKEW to VFIN+SKEW inclusive, with VBEG in register 5, VFIN in register 6 and SKEW in register 7. de_o is the AND of both windows, and it can change part way through a line.
- R6: Register 8 bit 0 set makes hsync_o active-low and bit 1 set makes vsync_o active-low. When idle, the outputs rest at the inactive level.
- R7: pix_ready_o equals de_o. Inside the window pix_o is pix_data_i when pix_valid_i is 1, and otherwise the underflow colour (register 10). Outside the window while running it is the border colour (register 9). When idle it is 0.
- R8: Register 11 holds a 2-bit depth code per component, component c in bits [2c+1:2c] and pixel byte c in pix_o[8c+7:8c]. Codes 0/1/2/3 keep the top 4/5/6/8 bits of the byte and zero the rest.
- R9: Writing register 0 bit 0 = 1 starts frame position 0 on the next clock. Clearing it stops the engine only after the last position of the current frame.
- R10: All timing, window, skew, polarity, colour and format settings are copied into a shadow at each frame start. A write during a frame affects only the following frames.
- R11: The line counter is 0 at each frame start and increments at each line restart inside the frame.
- R12: The frame counter (32 bits, wrapping) increments at each frame start, and vblank_o is 1 for exactly the first clock of each frame.
- R13: Register 12 bit 0 enables the line counter and bit 1 enables the frame counter. A disabled counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register index |
| cfg_wdata_i | input | 32 | Register write data |
| pix_valid_i | input | 1 | Upstream pixel valid |
| pix_data_i | input | 24 | Upstream pixel, three 8-bit components |
| pix_ready_o | output | 1 | Pixel accepted this cycle |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data enable |
| pix_o | output | 24 | Pixel to panel |
| vblank_o | output | 1 | One-cycle frame start pulse |
| line_cnt_o | output | 16 | Line counter |
| frame_cnt_o | output | 32 | Frame counter |

## Verification
The bench changes the vertical start and skew part way through a frame. A design without a working shadow would move the window in that same frame. The new bounds also put the window opening part way through a line, which a design that compares line numbers would round to a whole line. Clearing the enable mid-frame catches a design that stops at once and cuts the frame short. A mixed per-component depth code, an underflow run with the source starved, and counters turned off one at a time catch a swapped component mask, a wrong colour priority, and counters that keep running when they are disabled.

// File: rtl/disp_tg_pkg.sv
package disp_tg_pkg;
  parameter int unsigned DW    = 32;
  parameter int unsigned AW    = 4;
  parameter int unsigned HW    = 16;
  parameter int unsigned FW    = 24;
  parameter int unsigned LW    = 16;
  parameter int unsigned FCW   = 32;
  parameter int unsigned NCOMP = 3;
  parameter int unsigned CBITS = 8;
  parameter int unsigned PW    = NCOMP * CBITS;

  typedef enum logic [AW-1:0] {
    A_CTRL   = 4'd0,
    A_HTIME  = 4'd1,
    A_VPER   = 4'd2,
    A_VSW    = 4'd3,
    A_HWIN   = 4'd4,
    A_VBEG   = 4'd5,
    A_VFIN   = 4'd6,
    A_SKEW   = 4'd7,
    A_POL    = 4'd8,
    A_BORDER = 4'd9,
    A_UFLOW  = 4'd10,
    A_FMT    = 4'd11,
    A_CNTEN  = 4'd12
  } reg_addr_e;

  typedef struct packed {
    logic [HW-1:0]        hper;
    logic [HW-1:0]        hpw;
    logic [HW-1:0]        hbeg;
    logic [HW-1:0]        hfin;
    logic [FW-1:0]        vper;
    logic [FW-1:0]        vsw;
    logic [FW-1:0]        vbeg;
    logic [FW-1:0]        vfin;
    logic [FW-1:0]        skew;
    logic                 hs_lo;
    logic                 vs_lo;
    logic [PW-1:0]        border;
    logic [PW-1:0]        uflow;
    logic [2*NCOMP-1:0]   fmt;
  } tg_cfg_t;
endpackage

// File: rtl/disp_tg_regs.sv
module disp_tg_regs
  import disp_tg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output tg_cfg_t       cfg_o,
  output logic          en_o,
  output logic [1:0]    cnt_en_o
);
  localparam int unsigned HI = DW / 2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o       <= '0;
      cfg_o.uflow <= PW'(8'hFF);
      cfg_o.fmt   <= '1;
      en_o        <= 1'b0;
      cnt_en_o    <= 2'b00;
    end else if (we_i) begin
      case (reg_addr_e'(addr_i))
        A_CTRL:   en_o         <= wdata_i[0];
        A_HTIME: begin
                  cfg_o.hper   <= wdata_i[HW-1:0];
                  cfg_o.hpw    <= wdata_i[HI +: HW];
        end
        A_VPER:   cfg_o.vper   <= wdata_i[FW-1:0];
        A_VSW:    cfg_o.vsw    <= wdata_i[FW-1:0];
        A_HWIN: begin
                  cfg_o.hbeg   <= wdata_i[HW-1:0];
                  cfg_o.hfin   <= wdata_i[HI +: HW];
        end
        A_VBEG:   cfg_o.vbeg   <= wdata_i[FW-1:0];
        A_VFIN:   cfg_o.vfin   <= wdata_i[FW-1:0];
        A_SKEW:   cfg_o.skew   <= wdata_i[FW-1:0];
        A_POL: begin
                  cfg_o.hs_lo  <= wdata_i[0];
                  cfg_o.vs_lo  <= wdata_i[1];
        end
        A_BORDER: cfg_o.border <= wdata_i[PW-1:0];
        A_UFLOW:  cfg_o.uflow  <= wdata_i[PW-1:0];
        A_FMT:    cfg_o.fmt    <= wdata_i[2*NCOMP-1:0];
        A_CNTEN:  cnt_en_o     <= wdata_i[1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/disp_tg_timing.sv
module disp_tg_timing
  import disp_tg_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [1:0]     cnt_en_i,
  input  tg_cfg_t        cfg_i,
  output tg_cfg_t        sh_o,
  output logic           run_o,
  output logic           hs_act_o,
  output logic           vs_act_o,
  output logic           de_o,
  output logic           vblank_o,
  output logic [LW-1:0]  line_o,
  output logic [FCW-1:0] frame_o
);
  logic [HW-1:0] hcnt;
  logic [FW-1:0] fcnt;
  logic          wrap, line_end, enter, step;
  logic [FW:0]   vbeg_eff, vfin_eff, fpos;
  logic          h_in, v_in;

  assign wrap     = fcnt == (sh_o.vper - FW'(1));
  assign line_end = hcnt == (sh_o.hper - HW'(1));
  assign enter    = en_i && (!run_o || wrap);
  assign step     = run_o && !wrap && line_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o   <= 1'b0;
      hcnt    <= '0;
      fcnt    <= '0;
      sh_o    <= '0;
      line_o  <= '0;
      frame_o <= '0;
    end else begin
      if (enter) sh_o <= cfg_i;
      if (!run_o) begin
        if (en_i) begin
          run_o <= 1'b1;
          hcnt  <= '0;
          fcnt  <= '0;
        end
      end else if (wrap) begin
        hcnt <= '0;
        fcnt <= '0;
        if (!en_i) run_o <= 1'b0;  // deferred stop: frame completed
      end else begin
        fcnt <= fcnt + FW'(1);
        hcnt <= line_end ? '0 : hcnt + HW'(1);
      end
      if (cnt_en_i[0]) begin
        if (enter)     line_o <= '0;
        else if (step) line_o <= line_o + LW'(1);
      end
      if (cnt_en_i[1] && enter) frame_o <= frame_o + FCW'(1);
    end
  end

  // vertical bounds in frame-wide pixel clocks, skew added, one guard bit
  assign vbeg_eff = {1'b0, sh_o.vbeg} + {1'b0, sh_o.skew};
  assign vfin_eff = {1'b0, sh_o.vfin} + {1'b0, sh_o.skew};
  assign fpos     = {1'b0, fcnt};

  assign h_in     = (hcnt >= sh_o.hbeg) && (hcnt <= sh_o.hfin);
  assign v_in     = (fpos >= vbeg_eff) && (fpos <= vfin_eff);
  assign hs_act_o = run_o && (hcnt < sh_o.hpw);
  assign vs_act_o = run_o && (fcnt < sh_o.vsw);
  assign de_o     = run_o && h_in && v_in;
  assign vblank_o = run_o && (fcnt == '0);

  // R2
  hcnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && sh_o.hper != '0) |-> (hcnt < sh_o.hper));

  // R10
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && fcnt != '0) |-> $stable(sh_o));

  // R12
  frame_at_vblank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(frame_o) |-> vblank_o);

  // R11
  line_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cnt_en_i[0]) && vblank_o) |-> (line_o == '0));

  // R9
  late_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !en_i && !wrap) |=> run_o);
endmodule

// File: rtl/disp_tg_pixel.sv
module disp_tg_pixel
  import disp_tg_pkg::*;
(
  input  logic          run_i,
  input  logic          hs_act_i,
  input  logic          vs_act_i,
  input  logic          de_i,
  input  tg_cfg_t       sh_i,
  input  logic          pix_valid_i,
  input  logic [PW-1:0] pix_data_i,
  output logic          pix_ready_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic [PW-1:0] pix_o
);
  logic [PW-1:0] raw;

  assign hsync_o     = hs_act_i ^ sh_i.hs_lo;
  assign vsync_o     = vs_act_i ^ sh_i.vs_lo;
  assign de_o        = de_i;
  assign pix_ready_o = de_i;

  always_comb begin
    if (!run_i)            raw = '0;
    else if (!de_i)        raw = sh_i.border;
    else if (pix_valid_i)  raw = pix_data_i;
    else                   raw = sh_i.uflow;
  end

  for (genvar c = 0; c < NCOMP; c++) begin : g_comp
    logic [1:0]       code;
    logic [CBITS-1:0] mask;
    int               keep;
    assign code = sh_i.fmt[2*c +: 2];
    always_comb begin
      keep = (code == 2'd3) ? CBITS : 4 + int'(code);
      mask = ~((CBITS'(1) << (CBITS - keep)) - CBITS'(1));
    end
    assign pix_o[c*CBITS +: CBITS] = raw[c*CBITS +: CBITS] & mask;
  end
endmodule

// File: rtl/disp_tg_top.sv
module disp_tg_top
  import disp_tg_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_we_i,
  input  logic [AW-1:0]  cfg_addr_i,
  input  logic [DW-1:0]  cfg_wdata_i,
  input  logic           pix_valid_i,
  input  logic [PW-1:0]  pix_data_i,
  output logic           pix_ready_o,
  output logic           hsync_o,
  output logic           vsync_o,
  output logic           de_o,
  output logic [PW-1:0]  pix_o,
  output logic           vblank_o,
  output logic [LW-1:0]  line_cnt_o,
  output logic [FCW-1:0] frame_cnt_o
);
  tg_cfg_t    live_cfg, sh_cfg;
  logic       en, run, hs_act, vs_act, de;
  logic [1:0] cnt_en;

  disp_tg_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .addr_i   (cfg_addr_i),
    .wdata_i  (cfg_wdata_i),
    .cfg_o    (live_cfg),
    .en_o     (en),
    .cnt_en_o (cnt_en)
  );

  disp_tg_timing u_timing (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en),
    .cnt_en_i (cnt_en),
    .cfg_i    (live_cfg),
    .sh_o     (sh_cfg),
    .run_o    (run),
    .hs_act_o (hs_act),
    .vs_act_o (vs_act),
    .de_o     (de),
    .vblank_o (vblank_o),
    .line_o   (line_cnt_o),
    .frame_o  (frame_cnt_o)
  );

  disp_tg_pixel u_pixel (
    .run_i       (run),
    .hs_act_i    (hs_act),
    .vs_act_i    (vs_act),
    .de_i        (de),
    .sh_i        (sh_cfg),
    .pix_valid_i (pix_valid_i),
    .pix_data_i  (pix_data_i),
    .pix_ready_o (pix_ready_o),
    .hsync_o     (hsync_o),
    .vsync_o     (vsync_o),
    .de_o        (de_o),
    .pix_o       (pix_o)
  );
endmodule

// File: tb/sim_disp_tg_top.sv
`timescale 1ns/1ps
module sim_disp_tg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        pvalid = 1'b0;
  logic [23:0] pdata = '0;
  logic        pready, hs, vs, de, vb;
  logic [23:0] pix;
  logic [15:0] line;
  logic [31:0] frame;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int vb_seen = 0;
  bit starve = 0;
  bit chk_on = 0;
  bit done = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  disp_tg_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .pix_valid_i(pvalid), .pix_data_i(pdata), .pix_ready_o(pready),
    .hsync_o(hs), .vsync_o(vs), .de_o(de), .pix_o(pix), .vblank_o(vb),
    .line_cnt_o(line), .frame_cnt_o(frame)
  );

  // ---------------- behavioural reference model ----------------
  bit [31:0] lv [0:12];
  bit        m_run;
  int        m_h, m_f;
  longint    s_hp, s_hpw, s_hb, s_hf, s_vp, s_vw, s_vb, s_vf, s_sk;
  bit [1:0]  s_pol;
  bit [23:0] s_bord, s_uf;
  bit [5:0]  s_fmt;
  bit [15:0] m_line;
  bit [31:0] m_frame;

  task automatic m_load();
    s_hp   = lv[1] & 32'hFFFF;      s_hpw = lv[1] >> 16;
    s_hb   = lv[4] & 32'hFFFF;      s_hf  = lv[4] >> 16;
    s_vp   = lv[2] & 32'hFFFFFF;    s_vw  = lv[3] & 32'hFFFFFF;
    s_vb   = lv[5] & 32'hFFFFFF;    s_vf  = lv[6] & 32'hFFFFFF;
    s_sk   = lv[7] & 32'hFFFFFF;
    s_pol  = lv[8][1:0];
    s_bord = lv[9][23:0];  s_uf = lv[10][23:0];  s_fmt = lv[11][5:0];
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (lv[i]) lv[i] = 0;
      lv[10] = 32'hFF; lv[11] = 32'h3F;
      m_run = 0; m_h = 0; m_f = 0;
      s_hp = 0; s_hpw = 0; s_hb = 0; s_hf = 0; s_vp = 0; s_vw = 0;
      s_vb = 0; s_vf = 0; s_sk = 0; s_pol = 0; s_bord = 0; s_uf = 0; s_fmt = 0;
      m_line = 0; m_frame = 0;
    end else begin
      bit en_now, enter, stp;
      en_now = lv[0][0]; enter = 0; stp = 0;
      if (!m_run) begin
        if (en_now) begin m_run = 1; m_h = 0; m_f = 0; m_load(); enter = 1; end
      end else if (m_f == s_vp - 1) begin
        m_h = 0; m_f = 0;
        if (en_now) begin m_load(); enter = 1; end else m_run = 0;
      end else begin
        m_f++;
        if (m_h == s_hp - 1) begin m_h = 0; stp = 1; end else m_h++;
      end
      if (lv[12][0]) begin
        if (enter) m_line = 0; else if (stp) m_line++;
      end
      if (lv[12][1] && enter) m_frame++;
      if (we && addr <= 12) lv[addr] = wdata;
    end
  end

  function automatic bit [23:0] trunc(bit [23:0] v, bit [5:0] f);
    bit [23:0] r;
    for (int c = 0; c < 3; c++) begin
      int keep;
      bit [7:0] m;
      keep = (f[2*c +: 2] == 3) ? 8 : 4 + f[2*c +: 2];
      m = 8'hFF << (8 - keep);
      r[8*c +: 8] = v[8*c +: 8] & m;
    end
    return r;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s [%s] %s: actual=%0h expected=%0h t=%0t", req, phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && chk_on) begin
      bit e_hs, e_vs, e_de;
      bit [23:0] e_pix;
      e_hs = (m_run && m_h < s_hpw) ^ s_pol[0];
      e_vs = (m_run && m_f < s_vw) ^ s_pol[1];
      e_de = m_run && m_h >= s_hb && m_h <= s_hf && m_f >= s_vb + s_sk && m_f <= s_vf + s_sk;
      if (!m_run) e_pix = 0;
      else if (!e_de) e_pix = trunc(s_bord, s_fmt);
      else if (pvalid) e_pix = trunc(pdata, s_fmt);
      else e_pix = trunc(s_uf, s_fmt);
      chk("R2", "hsync", hs, e_hs);
      chk("R3", "vsync", vs, e_vs);
      chk("R5", "de", de, e_de);
      chk("R7", "ready", pready, e_de);
      chk("R7", "pix", pix, e_pix);
      chk("R11", "line", line, m_line);
      chk("R12", "frame", frame, m_frame);
      chk("R12", "vblank", vb, m_run && m_f == 0);
      if (vb) vb_seen++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(posedge clk); #1;
    we = 0;
    cyc++;
    pvalid = !starve && (cyc % 5 != 2);
    pdata = 24'(cyc * 32'h010307) ^ 24'hA5C3;
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(bit [3:0] a, bit [31:0] d);
    we = 1; addr = a; wdata = d;
    tick();
  endtask

  initial begin
    int fc0, vb0;
    bit [15:0] ln0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    @(negedge clk);
    chk("R1", "hsync", hs, 0);  chk("R1", "vsync", vs, 0);
    chk("R1", "de", de, 0);     chk("R1", "ready", pready, 0);
    chk("R1", "pix", pix, 0);   chk("R1", "vblank", vb, 0);
    chk("R1", "line", line, 0); chk("R1", "frame", frame, 0);
    rst_n = 1;
    tick();
    chk_on = 1;

    phase = "R4";
    wr(4'd12, 3);
    wr(4'd1, (2 << 16) | 10);
    wr(4'd4, (8 << 16) | 3);
    wr(4'd2, 80);
    wr(4'd3, 20);
    wr(4'd5, 25);
    wr(4'd6, 64);
    wr(4'd9, 24'h123456);
    // R9 start; first frame starved to show underflow colour (R7)
    starve = 1;
    phase = "R9";
    wr(4'd0, 1);
    steps(80);
    starve = 0;
    phase = "R7";
    steps(80);
    chk("R12", "frame count vs vblank pulses", frame, vb_seen);

    // R10 mid-frame change; new vertical start lands mid-line (R5)
    phase = "R10";
    steps(30);
    wr(4'd7, 5);
    wr(4'd5, 23);
    steps(200);

    phase = "R8";
    wr(4'd8, 3);            // R6 both syncs active-low
    wr(4'd11, 6'b00_01_10);
    wr(4'd10, 24'hABCDEF);
    steps(200);

    // R13 counter enables
    phase = "R13";
    wr(4'd12, 1);
    fc0 = frame;
    steps(200);
    @(negedge clk);
    chk("R13", "frame held", frame, fc0);
    tick();
    wr(4'd12, 0);
    ln0 = line;
    steps(50);
    @(negedge clk);
    chk("R13", "line held", line, ln0);
    tick();
    wr(4'd12, 3);
    steps(100);

    // R9 late stop
    phase = "R9";
    steps(17);
    wr(4'd0, 0);
    steps(200);
    vb0 = vb_seen;
    steps(100);
    @(negedge clk);
    chk("R9", "no frame after stop", vb_seen, vb0);
    chk("R9", "de idle", de, 0);
    tick();
    wr(4'd1, (3 << 16) | 12);
    wr(4'd2, 96);
    wr(4'd0, 1);
    steps(250);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R9 watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule